// File: doc/BRIEF.md
# Sub-word Load/Store Lane Aligner

This unit sits between a word-wide data memory port and the register file of a small 32-bit RISC core. It handles every access narrower than a full word. A load presents the fetched memory word, the two low address bits, the access width and a zero-extend flag. One cycle later the unit returns a register-width value: the addressed lane is moved to the bottom and sign- or zero-extended.

A store presents the source register value, the low address bits and the width. One cycle later the unit returns a write-data word and a per-byte write-enable mask, so the memory changes only the addressed lane. The bottom byte or halfword of the register is copied into every lane of the write data. The mask then picks the lane that is actually written.

Byte order is big-endian: lane offset 0 is the most significant byte of the memory word. Address generation, misalignment traps and the memory itself are outside this unit.

Top module: `subword_align_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, all outputs are cleared to zero on that edge.
- R2: `rsp_valid` is high exactly one clock after `req_valid` was high, and low one clock after it was low.
- R3: A signed byte load (`acc_size`=00, `ld_zext`=0) returns memory bits [31-8k:24-8k], with k = `addr_lo`, sign-extended to 32 bits.
- R4: An unsigned byte load (`acc_size`=00, `ld_zext`=1) returns the same lane as R3, zero-extended.
- R5: A signed halfword load (`acc_size`=01, `ld_zext`=0) returns memory bits [31:16] when `addr_lo[1]`=0 and bits [15:0] when it is 1, sign-extended; `addr_lo[0]` has no effect.
- R6: An unsigned halfword load (`acc_size`=01, `ld_zext`=1) returns the halfword chosen as in R5, zero-extended.
- R7: A word load (`acc_size`=10) returns the memory word unchanged, whatever the values of `ld_zext` and `addr_lo`.
- R8: A byte store (`acc_size`=00) drives `st_wdata` with four copies of `reg_wdata[7:0]` and sets only bit 3-k of `st_be`, with k = `addr_lo`.
- R9: A halfword store (`acc_size`=01) drives `st_wdata` with two copies of `reg_wdata[15:0]`. It sets `st_be`=1100 when `addr_lo[1]`=0 and 0011 when it is 1.
- R10: A word store (`acc_size`=10) drives `st_wdata` equal to `reg_wdata` and sets `st_be`=1111.
- R11: A store response has `ld_result`=0. A load response has `st_wdata`=0 and `st_be`=0. A cycle with no request gives all data outputs zero.
- R12: The unused width code 11 behaves exactly like a word access, for loads and for stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| is_store | input | 1 | 1 = store request, 0 = load request |
| acc_size | input | 2 | Access width: 00 byte, 01 halfword, 10 word, 11 treated as word |
| ld_zext | input | 1 | Load only: 1 zero-extends, 0 sign-extends |
| addr_lo | input | 2 | Low two bits of the effective address |
| mem_rdata | input | 32 | Word read from data memory (loads) |
| reg_wdata | input | 32 | Source register value (stores) |
| rsp_valid | output | 1 | Registered response valid |
| ld_result | output | 32 | Aligned and extended load value |
| st_wdata | output | 32 | Lane-replicated store data |
| st_be | output | 4 | Byte write enables, bit 3 = bits 31:24 |

## Verification
The hardest cases to reach are those where an input must have no effect. Examples are `addr_lo[0]` on a halfword access, `ld_zext` on a word load, and the unused width code 11. A free-running random stream rarely lands on the exact pairs that would expose a wrong lane choice. The stimulus therefore first sweeps every combination of direction, width, extension flag and offset. It runs each combination against memory words whose lanes carry distinct values with alternating top bits, so a wrong lane or a wrong fill bit changes the result. Back-to-back random requests with idle gaps then follow, to cover the one-cycle response timing and the clearing of the unused outputs.

// File: rtl/subword_align_pkg.sv
package subword_align_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned LANE_W = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic      load;
        logic      store;
        acc_size_e size;
        logic      zext;
    } req_dec_t;

    // Width code 11 is folded onto a full-word access.
    function automatic logic size_is_word(input acc_size_e sz);
        return (sz == SZ_WORD) || (sz == SZ_RSVD);
    endfunction

    function automatic req_dec_t decode_req(input logic valid, input logic st,
                                            input logic [1:0] sz, input logic zx);
        req_dec_t d;
        d.load  = valid & ~st;
        d.store = valid & st;
        d.size  = acc_size_e'(sz);
        d.zext  = zx;
        return d;
    endfunction

endpackage

// File: rtl/subword_load_extract.sv
module subword_load_extract
    import subword_align_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [DATA_W-1:0]                      mem_word,
    input  logic [$clog2(DATA_W/BYTE_W)-1:0]       lane_idx,
    input  acc_size_e                              size,
    input  logic                                   zext,
    output logic [DATA_W-1:0]                      result
);
    localparam int unsigned LANES  = DATA_W / BYTE_W;
    localparam int unsigned HALF_W = 2 * BYTE_W;
    localparam int unsigned NHALF  = LANES / 2;
    localparam int unsigned IDX_W  = $clog2(LANES);

    logic [BYTE_W-1:0] byte_lane [LANES];
    logic [HALF_W-1:0] half_lane [NHALF];

    // Big-endian: lane 0 is the most significant slice.
    for (genvar g = 0; g < LANES; g++) begin : g_byte
        assign byte_lane[g] = mem_word[DATA_W-1-g*BYTE_W -: BYTE_W];
    end
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        assign half_lane[h] = mem_word[DATA_W-1-h*HALF_W -: HALF_W];
    end

    logic [BYTE_W-1:0] byte_sel;
    logic [HALF_W-1:0] half_sel;
    logic              byte_fill;
    logic              half_fill;

    assign byte_sel  = byte_lane[lane_idx];
    assign half_sel  = half_lane[lane_idx[IDX_W-1:1]];
    assign byte_fill = ~zext & byte_sel[BYTE_W-1];
    assign half_fill = ~zext & half_sel[HALF_W-1];

    always_comb begin
        if (size_is_word(size)) begin
            result = mem_word;
        end else if (size == SZ_HALF) begin
            result = {{(DATA_W-HALF_W){half_fill}}, half_sel};
        end else begin
            result = {{(DATA_W-BYTE_W){byte_fill}}, byte_sel};
        end
    end
endmodule

// File: rtl/subword_store_merge.sv
module subword_store_merge
    import subword_align_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [DATA_W-1:0]                      src,
    input  logic [$clog2(DATA_W/BYTE_W)-1:0]       lane_idx,
    input  acc_size_e                              size,
    output logic [DATA_W-1:0]                      wdata,
    output logic [DATA_W/BYTE_W-1:0]               be
);
    localparam int unsigned LANES  = DATA_W / BYTE_W;
    localparam int unsigned HALF_W = 2 * BYTE_W;
    localparam int unsigned NHALF  = LANES / 2;
    localparam int unsigned IDX_W  = $clog2(LANES);

    logic [LANES-1:0] be_byte;
    logic [LANES-1:0] be_half;

    // Enable bit LANES-1-g covers lane g (big-endian lane order).
    for (genvar g = 0; g < LANES; g++) begin : g_be
        assign be_byte[LANES-1-g] = (lane_idx == IDX_W'(g));
        assign be_half[LANES-1-g] = (lane_idx[IDX_W-1:1] == (IDX_W-1)'(g / 2));
    end

    always_comb begin
        if (size_is_word(size)) begin
            wdata = src;
            be    = '1;
        end else if (size == SZ_HALF) begin
            wdata = {NHALF{src[HALF_W-1:0]}};
            be    = be_half;
        end else begin
            wdata = {LANES{src[BYTE_W-1:0]}};
            be    = be_byte;
        end
    end
endmodule

// File: rtl/subword_align_unit.sv
module subword_align_unit
    import subword_align_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned BYTE_W = LANE_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic                        is_store,
    input  logic [1:0]                  acc_size,
    input  logic                        ld_zext,
    input  logic [1:0]                  addr_lo,
    input  logic [DATA_W-1:0]           mem_rdata,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic                        rsp_valid,
    output logic [DATA_W-1:0]           ld_result,
    output logic [DATA_W-1:0]           st_wdata,
    output logic [DATA_W/BYTE_W-1:0]    st_be
);
    localparam int unsigned LANES = DATA_W / BYTE_W;

    req_dec_t          dec;
    logic [DATA_W-1:0] ld_next;
    logic [DATA_W-1:0] st_next;
    logic [LANES-1:0]  be_next;

    assign dec = decode_req(req_valid, is_store, acc_size, ld_zext);

    subword_load_extract #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_load (
        .mem_word (mem_rdata),
        .lane_idx (addr_lo),
        .size     (dec.size),
        .zext     (dec.zext),
        .result   (ld_next)
    );

    subword_store_merge #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_store (
        .src      (reg_wdata),
        .lane_idx (addr_lo),
        .size     (dec.size),
        .wdata    (st_next),
        .be       (be_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            ld_result <= '0;
            st_wdata  <= '0;
            st_be     <= '0;
        end else begin
            rsp_valid <= req_valid;
            ld_result <= dec.load  ? ld_next : '0;
            st_wdata  <= dec.store ? st_next : '0;
            st_be     <= dec.store ? be_next : '0;
        end
    end
endmodule

// File: rtl/subword_align_chk.sv
module subword_align_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BYTE_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     req_valid,
    input logic                     is_store,
    input logic [1:0]               acc_size,
    input logic                     ld_zext,
    input logic                     rsp_valid,
    input logic [DATA_W-1:0]        ld_result,
    input logic [DATA_W-1:0]        st_wdata,
    input logic [DATA_W/BYTE_W-1:0] st_be
);
    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r2_no_rsp_when_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    a_r3_byte_sign_fill: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !is_store && acc_size == 2'b00 && !ld_zext) |=>
        ((ld_result[DATA_W-1:BYTE_W-1] == '0) || (&ld_result[DATA_W-1:BYTE_W-1])));
    a_r4_byte_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !is_store && acc_size == 2'b00 && ld_zext) |=>
        (ld_result[DATA_W-1:BYTE_W] == '0));
    a_r6_half_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !is_store && acc_size == 2'b01 && ld_zext) |=>
        (ld_result[DATA_W-1:2*BYTE_W] == '0));
    a_r8_one_byte_enable: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_store && acc_size == 2'b00) |=> ($countones(st_be) == 1));
    a_r9_two_byte_enables: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_store && acc_size == 2'b01) |=> ($countones(st_be) == 2));
    a_r10_all_enables: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_store && acc_size[1]) |=> (&st_be));
    a_r11_store_clears_load: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_store) |=> (ld_result == '0));
    a_r11_load_no_enable: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && is_store) |=> (st_be == '0 && st_wdata == '0));
endmodule

bind subword_align_unit subword_align_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .is_store  (is_store),
    .acc_size  (acc_size),
    .ld_zext   (ld_zext),
    .rsp_valid (rsp_valid),
    .ld_result (ld_result),
    .st_wdata  (st_wdata),
    .st_be     (st_be)
);

// File: tb/subword_align_unit_tb_top.sv
module subword_align_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        is_store = 1'b0;
    logic [1:0]  acc_size = 2'b00;
    logic        ld_zext = 1'b0;
    logic [1:0]  addr_lo = 2'b00;
    logic [31:0] mem_rdata = '0;
    logic [31:0] reg_wdata = '0;
    logic        rsp_valid;
    logic [31:0] ld_result;
    logic [31:0] st_wdata;
    logic [3:0]  st_be;

    int checks = 0;
    int failures = 0;
    bit have_exp = 0;

    // Expected response of the last driven request.
    logic        e_valid;
    logic [31:0] e_ld, e_wd;
    logic [3:0]  e_be;
    string       e_tag;

    always #4 clk = ~clk;  // 125 MHz

    subword_align_unit dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .is_store(is_store),
        .acc_size(acc_size), .ld_zext(ld_zext), .addr_lo(addr_lo),
        .mem_rdata(mem_rdata), .reg_wdata(reg_wdata), .rsp_valid(rsp_valid),
        .ld_result(ld_result), .st_wdata(st_wdata), .st_be(st_be)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    // Behavioural reference computed from the requirements.
    task automatic model(input bit v, input bit st, input int sz, input bit zx,
                         input int a, input logic [31:0] mem, input logic [31:0] src);
        int     w;
        int     sh;
        logic [31:0] raw;
        e_valid = v;
        e_ld = 0; e_wd = 0; e_be = 0;
        w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        if (!v) begin
            e_tag = "R11";
        end else if (st) begin
            e_tag = (sz == 0) ? "R8" : (sz == 1) ? "R9" : (sz == 2) ? "R10" : "R12";
            if (w == 8) begin
                e_wd = {4{src[7:0]}};
                e_be = 4'b1000 >> a;
            end else if (w == 16) begin
                e_wd = {2{src[15:0]}};
                e_be = (a >= 2) ? 4'b0011 : 4'b1100;
            end else begin
                e_wd = src;
                e_be = 4'b1111;
            end
        end else begin
            if (sz == 0) e_tag = zx ? "R4" : "R3";
            else if (sz == 1) e_tag = zx ? "R6" : "R5";
            else e_tag = (sz == 2) ? "R7" : "R12";
            if (w == 32) begin
                e_ld = mem;
            end else begin
                sh  = (w == 8) ? 8 * (3 - a) : ((a >= 2) ? 0 : 16);
                raw = (mem >> sh) & ((32'd1 << w) - 1);
                if (!zx && raw[w-1]) raw = raw | ~((32'd1 << w) - 1);
                e_ld = raw;
            end
        end
    endtask

    task automatic compare();
        if (have_exp) begin
            check("R2", "rsp_valid", {31'd0, rsp_valid}, {31'd0, e_valid});
            check(e_tag, "ld_result", ld_result, e_ld);
            check(e_tag, "st_wdata", st_wdata, e_wd);
            check(e_tag, "st_be", {28'd0, st_be}, {28'd0, e_be});
        end
    endtask

    task automatic step(input bit v, input bit st, input int sz, input bit zx,
                        input int a, input logic [31:0] mem, input logic [31:0] src);
        @(negedge clk);
        compare();
        req_valid = v; is_store = st; acc_size = sz[1:0]; ld_zext = zx;
        addr_lo = a[1:0]; mem_rdata = mem; reg_wdata = src;
        model(v, st, sz, zx, a, mem, src);
        have_exp = 1;
    endtask

    initial begin
        logic [31:0] pats [3];
        pats[0] = 32'h8A_3B_C4_5D;
        pats[1] = 32'h17_F2_6E_93;
        pats[2] = 32'hFF_00_80_7F;
        // R1: reset clears the outputs even with a request present.
        req_valid = 1'b1; is_store = 1'b1; acc_size = 2'b10; reg_wdata = 32'hDEADBEEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1", "ld_result", ld_result, 32'd0);
        check("R1", "st_wdata", st_wdata, 32'd0);
        check("R1", "st_be", {28'd0, st_be}, 32'd0);
        rst = 1'b0; req_valid = 1'b0;
        // Exhaustive sweep of direction, width, extension flag and offset.
        for (int p = 0; p < 3; p++)
            for (int st = 0; st < 2; st++)
                for (int sz = 0; sz < 4; sz++)
                    for (int zx = 0; zx < 2; zx++)
                        for (int a = 0; a < 4; a++)
                            step(1'b1, st[0], sz, zx[0], a, pats[p], ~pats[p] ^ 32'h0000_0180);
        // Random traffic with idle gaps.
        for (int i = 0; i < 600; i++)
            step(($urandom % 4) != 0, $urandom % 2, $urandom % 4, $urandom % 2,
                 $urandom % 4, $urandom, $urandom);
        step(1'b0, 1'b0, 0, 1'b0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        step(1'b0, 1'b0, 0, 1'b0, 0, 0, 0);
        @(negedge clk);
        compare();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule